// File: doc/BRIEF.md
# Debug Port Access Sequencer

This block sits between a debug controller and a JTAG scan engine. It takes one register request at a time, addressed either to the debug port or to an access port. Each request carries a 2-bit register address, a read/write flag and 32 bits of write data. The block turns the request into a sequence of scans for the engine. It remembers which access instruction is loaded in the 4-bit instruction register, so an instruction scan is issued only when the next access needs the other instruction.

Each access is a 35-bit data-register scan. Reads are posted: the scan that starts a read returns nothing useful. After a successful read, the block runs a second scan, a debug-port read of the read-buffer register, and takes the result from that scan. If that needs the debug-port instruction and the access-port instruction is loaded, the block issues an instruction scan first.

The low three captured bits of every access scan are an acknowledge code. A wait code causes the identical scan to be repeated, up to a limit. Any code other than OK or wait ends the request at once.

Top module: `dap_access_seq`

## Requirements
- R1: Out of reset, req_ready is 1, and both resp_valid and scan_go are 0.
- R2: An instruction scan has scan_ir = 1 and scan_len = 4. scan_out carries 0xA for the debug-port access instruction or 0xB for the access-port access instruction, and zero above bit 3. The first request after reset always starts with an instruction scan.
- R3: A request of the same kind (debug-port or access-port) as the instruction already loaded issues no instruction scan, only data scans.
- R4: A data scan has scan_ir = 0 and scan_len = 35. In scan_out, bit 0 is the read flag (1 = read), bits 2:1 are the register address and bits 34:3 are the write data (zero for reads).
- R5: A write whose scan captures acknowledge 010 (OK) in scan_in[2:0] ends with a one-cycle resp_valid, resp_ack = 010 and resp_rdata = 0.
- R6: A read whose access scan returns OK is followed by a debug-port read of the read-buffer register: address 2'b11, read flag 1, data 0. resp_rdata is then scan_in[34:3] of that retrieval scan.
- R7: If the access-port instruction is loaded when a read needs its result, the retrieval is preceded by an instruction scan of 0xA. The next access-port request then reloads 0xB.
- R8: Acknowledge 001 (WAIT) repeats the identical scan, up to 4 retries. If every retry also returns WAIT, the request ends with resp_ack = 001, resp_rdata = 0 and no retrieval scan.
- R9: Any acknowledge other than 010 or 001 ends the request at once. resp_ack echoes the code, resp_rdata is 0, and a read gets no retrieval scan.
- R10: req_ready falls in the cycle after a request is accepted. It stays low until the response, so no second request is taken meanwhile.
- R11: scan_go is a one-cycle pulse. The next scan is not requested before scan_done has returned for the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| req_addr | input | 2 | Register address (word index) |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_ack | output | 3 | Final acknowledge code |
| resp_rdata | output | 32 | Read result, zero otherwise |
| scan_go | output | 1 | Start one scan |
| scan_ir | output | 1 | 1 = instruction scan, 0 = data scan |
| scan_len | output | 6 | Scan length in bits |
| scan_out | output | 35 | Bits shifted toward the target |
| scan_done | input | 1 | Scan finished pulse |
| scan_in | input | 35 | Bits captured by the finished scan |

## Verification
Several request patterns are compared against a scoreboard of expected scans and responses.
- A debug-port read straight after reset separates the forced first instruction load and the posted retrieval from a design that returns data from the access scan.
- Runs of same-kind requests, and then switches between kinds, show whether the instruction cache skips or reloads correctly. This includes the switch forced by an access-port read's retrieval.
- Acknowledge patterns separate a recovered wait, an exhausted wait and a fault. For each, the check is whether the same payload is repeated and whether the retrieval is correctly suppressed.

// File: rtl/dap_seq_pkg.sv
package dap_seq_pkg;
   localparam int ACK_W = 3;
   localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;
   localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_IR_GO,
      ST_IR_WAIT,
      ST_DR_GO,
      ST_DR_WAIT
   } seq_state_t;
endpackage

// File: rtl/dap_payload_fmt.sv
module dap_payload_fmt #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     rnw,
   input  logic [DATA_W-1:0]        data,
   output logic [DATA_W+ADDR_W:0]   payload
);
   // read flag lowest, register index next, data word on top
   always_comb payload = {data, addr, rnw};
endmodule

// File: rtl/dap_ir_cache.sv
module dap_ir_cache #(
   parameter int               IR_W     = 4,
   parameter logic [IR_W-1:0]  IR_DPACC = 4'hA,
   parameter logic [IR_W-1:0]  IR_APACC = 4'hB
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            load_ap,
   input  logic            tgt_ap,
   output logic            held_valid,
   output logic            held_ap,
   output logic [IR_W-1:0] tgt_code
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_valid <= 1'b0;
         held_ap    <= 1'b0;
      end else if (load) begin
         held_valid <= 1'b1;
         held_ap    <= load_ap;
      end
   end

   always_comb tgt_code = tgt_ap ? IR_APACC : IR_DPACC;
endmodule

// File: rtl/dap_retry_ctr.sv
module dap_retry_ctr #(
   parameter int MAX_RETRY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic exhausted
);
   generate
      if (MAX_RETRY == 0) begin : g_no_retry
         logic unused_in;
         always_comb unused_in = clk ^ rst_n ^ clr ^ inc;
         always_comb exhausted = 1'b1;
      end else begin : g_retry
         localparam int RTRY_W = $clog2(MAX_RETRY + 1);
         logic [RTRY_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (clr) cnt <= '0;
            else if (inc) cnt <= cnt + 1'b1;
         end
         always_comb exhausted = (cnt == RTRY_W'(MAX_RETRY));
      end
   endgenerate
endmodule

// File: rtl/dap_access_seq.sv
module dap_access_seq
   import dap_seq_pkg::*;
#(
   parameter int               DATA_W      = 32,
   parameter int               ADDR_W      = 2,
   parameter int               IR_W        = 4,
   parameter logic [IR_W-1:0]  IR_DPACC    = 4'hA,
   parameter logic [IR_W-1:0]  IR_APACC    = 4'hB,
   parameter logic [ADDR_W-1:0] RDBUFF_ADDR = 2'b11,
   parameter int               MAX_RETRY   = 4,
   localparam int              PAY_W       = DATA_W + ADDR_W + 1,
   localparam int              LEN_W       = $clog2(PAY_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_ap,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_rnw,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              resp_valid,
   output logic [ACK_W-1:0]  resp_ack,
   output logic [DATA_W-1:0] resp_rdata,
   output logic              scan_go,
   output logic              scan_ir,
   output logic [LEN_W-1:0]  scan_len,
   output logic [PAY_W-1:0]  scan_out,
   input  logic              scan_done,
   input  logic [PAY_W-1:0]  scan_in
);
   // elaboration-time parameter checks
   generate
      if (IR_DPACC == IR_APACC) begin : g_bad_ir
         $error("access instruction codes must differ");
      end
      if (ADDR_W + 1 != ACK_W) begin : g_bad_ack
         $error("acknowledge field must fill address and read-flag positions");
      end
      if (IR_W > PAY_W) begin : g_bad_irw
         $error("instruction wider than data payload");
      end
      if (MAX_RETRY < 0) begin : g_bad_rty
         $error("retry limit must not be negative");
      end
   endgenerate

   seq_state_t state;
   logic              ap_q, rnw_q, phase_rd;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   logic              held_valid, held_ap;
   logic              ir_tgt_ap;
   logic [IR_W-1:0]   ir_code;
   logic              hit_req, hit_dp;

   logic [ADDR_W-1:0] f_addr;
   logic              f_rnw;
   logic [DATA_W-1:0] f_data;
   logic [PAY_W-1:0]  payload;

   logic              dr_end, ack_ok, ack_wait;
   logic              exhausted, rty_clr, rty_inc, go_retrieve;
   logic [ACK_W-1:0]  cap_ack;

   // instruction that the current step needs; retrieval always uses debug port
   always_comb ir_tgt_ap = ap_q && !phase_rd;
   always_comb hit_req   = held_valid && (held_ap == req_ap);
   always_comb hit_dp    = held_valid && !held_ap;

   dap_ir_cache #(
      .IR_W     (IR_W),
      .IR_DPACC (IR_DPACC),
      .IR_APACC (IR_APACC)
   ) u_ir_cache (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       ((state == ST_IR_WAIT) && scan_done),
      .load_ap    (ir_tgt_ap),
      .tgt_ap     (ir_tgt_ap),
      .held_valid (held_valid),
      .held_ap    (held_ap),
      .tgt_code   (ir_code)
   );

   always_comb begin
      f_addr = phase_rd ? RDBUFF_ADDR : addr_q;
      f_rnw  = phase_rd ? 1'b1 : rnw_q;
      f_data = phase_rd ? '0 : (rnw_q ? '0 : wdata_q);
   end

   dap_payload_fmt #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_fmt (
      .addr    (f_addr),
      .rnw     (f_rnw),
      .data    (f_data),
      .payload (payload)
   );

   always_comb begin
      cap_ack     = scan_in[ACK_W-1:0];
      dr_end      = (state == ST_DR_WAIT) && scan_done;
      ack_ok      = (cap_ack == ACK_OK);
      ack_wait    = (cap_ack == ACK_WAIT);
      rty_inc     = dr_end && ack_wait && !exhausted;
      go_retrieve = dr_end && ack_ok && !phase_rd && rnw_q;
      rty_clr     = (state == ST_IDLE) || go_retrieve;
   end

   dap_retry_ctr #(
      .MAX_RETRY (MAX_RETRY)
   ) u_retry (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (rty_clr),
      .inc       (rty_inc),
      .exhausted (exhausted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ap_q       <= 1'b0;
         rnw_q      <= 1'b0;
         phase_rd   <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
         resp_valid <= 1'b0;
         resp_ack   <= '0;
         resp_rdata <= '0;
      end else begin
         resp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  ap_q     <= req_ap;
                  addr_q   <= req_addr;
                  rnw_q    <= req_rnw;
                  wdata_q  <= req_wdata;
                  phase_rd <= 1'b0;
                  state    <= hit_req ? ST_DR_GO : ST_IR_GO;
               end
            end
            ST_IR_GO:   state <= ST_IR_WAIT;
            ST_IR_WAIT: if (scan_done) state <= ST_DR_GO;
            ST_DR_GO:   state <= ST_DR_WAIT;
            ST_DR_WAIT: begin
               if (scan_done) begin
                  if (rty_inc) begin
                     state <= ST_DR_GO;
                  end else if (go_retrieve) begin
                     phase_rd <= 1'b1;
                     state    <= hit_dp ? ST_DR_GO : ST_IR_GO;
                  end else begin
                     resp_valid <= 1'b1;
                     resp_ack   <= cap_ack;
                     resp_rdata <= (phase_rd && ack_ok) ? scan_in[PAY_W-1:ACK_W] : '0;
                     state      <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready = (state == ST_IDLE);
      scan_go   = (state == ST_IR_GO) || (state == ST_DR_GO);
      scan_ir   = (state == ST_IR_GO);
      scan_len  = scan_ir ? LEN_W'(IR_W) : LEN_W'(PAY_W);
      scan_out  = scan_ir ? PAY_W'(ir_code) : payload;
   end
endmodule

// File: rtl/dap_access_seq_chk.sv
module dap_access_seq_chk #(
   parameter int               DATA_W   = 32,
   parameter int               IR_W     = 4,
   parameter int               PAY_W    = 35,
   parameter int               LEN_W    = 6,
   parameter logic [IR_W-1:0]  IR_DPACC = 4'hA,
   parameter logic [IR_W-1:0]  IR_APACC = 4'hB
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              resp_valid,
   input logic [2:0]        resp_ack,
   input logic [DATA_W-1:0] resp_rdata,
   input logic              scan_go,
   input logic              scan_ir,
   input logic [LEN_W-1:0]  scan_len,
   input logic [PAY_W-1:0]  scan_out
);
   logic was_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) was_rst <= 1'b1;
      else        was_rst <= 1'b0;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      was_rst |-> (req_ready && !resp_valid && !scan_go));

   // R2
   ir_scan_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_go && scan_ir) |-> (scan_len == LEN_W'(IR_W)) &&
         ((scan_out == PAY_W'(IR_DPACC)) || (scan_out == PAY_W'(IR_APACC))));

   // R4
   dr_scan_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_go && !scan_ir) |-> (scan_len == LEN_W'(PAY_W)));

   // R9
   err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_ack != 3'b010) |-> (resp_rdata == '0));

   // R10
   busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10
   resp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> req_ready);

   // R11
   go_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_go |=> !scan_go);

   // R11
   no_go_while_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !scan_go);
endmodule

bind dap_access_seq dap_access_seq_chk #(
   .DATA_W   (DATA_W),
   .IR_W     (IR_W),
   .PAY_W    (PAY_W),
   .LEN_W    (LEN_W),
   .IR_DPACC (IR_DPACC),
   .IR_APACC (IR_APACC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .resp_valid (resp_valid),
   .resp_ack   (resp_ack),
   .resp_rdata (resp_rdata),
   .scan_go    (scan_go),
   .scan_ir    (scan_ir),
   .scan_len   (scan_len),
   .scan_out   (scan_out)
);

// File: tb/tb_dap_access_seq.sv
`timescale 1ns/1ps
module tb_dap_access_seq;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_ap, req_rnw;
   logic [1:0]  req_addr;
   logic [31:0] req_wdata;
   logic        resp_valid;
   logic [2:0]  resp_ack;
   logic [31:0] resp_rdata;
   logic        scan_go, scan_ir, scan_done;
   logic [5:0]  scan_len;
   logic [34:0] scan_out, scan_in;

   always #4 clk = ~clk;

   dap_access_seq dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_ap(req_ap),
      .req_addr(req_addr), .req_rnw(req_rnw), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_rdata(resp_rdata),
      .scan_go(scan_go), .scan_ir(scan_ir), .scan_len(scan_len),
      .scan_out(scan_out), .scan_done(scan_done), .scan_in(scan_in)
   );

   int checks = 0;
   int fails  = 0;

   logic [41:0] exp_scan[$];
   string       scan_tag[$];
   logic [34:0] exp_resp[$];
   string       resp_tag[$];
   logic [34:0] capq[$];
   logic        prev_go = 1'b0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic exp_ir(input logic [3:0] code, input string tag);
      exp_scan.push_back({1'b1, 6'd4, 35'(code)});
      scan_tag.push_back(tag);
   endtask

   task automatic exp_dr(input logic [1:0] a, input logic rd, input logic [31:0] d, input string tag);
      exp_scan.push_back({1'b0, 6'd35, d, a, rd});
      scan_tag.push_back(tag);
   endtask

   task automatic exp_rsp(input logic [2:0] ack, input logic [31:0] d, input string tag);
      exp_resp.push_back({d, ack});
      resp_tag.push_back(tag);
   endtask

   task automatic cap(input logic [2:0] ack, input logic [31:0] d);
      capq.push_back({d, ack});
   endtask

   // driver: present one request, then wait for its response
   task automatic issue(input logic ap, input logic [1:0] a, input logic rd, input logic [31:0] d);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_ap = ap; req_addr = a; req_rnw = rd; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 busy after accept", 64'(req_ready), 64'd0);
      do @(negedge clk); while (!resp_valid);
   endtask

   // scan engine model: answers each scan two cycles later
   always begin
      @(negedge clk);
      scan_done = 1'b0;
      if (rst_n && scan_go) begin
         logic is_ir;
         is_ir = scan_ir;
         repeat (2) @(negedge clk);
         if (is_ir)                scan_in = '0;
         else if (capq.size() > 0) scan_in = capq.pop_front();
         else                      scan_in = {32'h0, 3'b010};
         scan_done = 1'b1;
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (scan_go) begin
            chk("R11 scan_go single pulse", 64'(prev_go), 64'd0);
            if (exp_scan.size() == 0) chk("R3 unexpected scan", 64'({scan_ir, scan_len, scan_out}), 64'd0);
            else chk(scan_tag.pop_front(), 64'({scan_ir, scan_len, scan_out}), 64'(exp_scan.pop_front()));
         end
         if (resp_valid) begin
            if (exp_resp.size() == 0) chk("R5 unexpected response", 64'({resp_rdata, resp_ack}), 64'd0);
            else chk(resp_tag.pop_front(), 64'({resp_rdata, resp_ack}), 64'(exp_resp.pop_front()));
         end
      end
      prev_go = scan_go;
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_ap = 1'b0; req_addr = '0;
      req_rnw = 1'b0; req_wdata = '0; scan_done = 1'b0; scan_in = '0;
      repeat (3) @(negedge clk);
      chk("R1 req_ready in reset", 64'(req_ready), 64'd1);
      chk("R1 resp_valid in reset", 64'(resp_valid), 64'd0);
      chk("R1 scan_go in reset", 64'(scan_go), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", 64'({req_ready, resp_valid, scan_go}), 64'b100);

      // identification read on the debug port right after reset
      exp_ir(4'hA, "R2 first request loads DP instruction");
      exp_dr(2'b00, 1'b1, 32'h0, "R4 DP read payload");
      cap(3'b010, 32'h0);
      exp_dr(2'b11, 1'b1, 32'h0, "R6 retrieval scan");
      cap(3'b010, 32'h2BA0_1477);
      exp_rsp(3'b010, 32'h2BA0_1477, "R6 read result");
      issue(1'b0, 2'b00, 1'b1, 32'h0);

      // DP write, instruction already loaded
      exp_dr(2'b10, 1'b0, 32'h0000_00F0, "R3 DP write without IR scan");
      cap(3'b010, 32'h0);
      exp_rsp(3'b010, 32'h0, "R5 write response");
      issue(1'b0, 2'b10, 1'b0, 32'h0000_00F0);

      // AP write: switch instruction
      exp_ir(4'hB, "R2 switch to AP instruction");
      exp_dr(2'b01, 1'b0, 32'h2000_0000, "R4 AP write payload");
      cap(3'b010, 32'h0);
      exp_rsp(3'b010, 32'h0, "R5 AP write response");
      issue(1'b1, 2'b01, 1'b0, 32'h2000_0000);

      // AP read: posted, retrieval needs DP instruction
      exp_dr(2'b11, 1'b1, 32'h0, "R3 AP read reuses AP instruction");
      cap(3'b010, 32'h5555_0000);
      exp_ir(4'hA, "R7 reload DP instruction for retrieval");
      exp_dr(2'b11, 1'b1, 32'h0, "R7 retrieval after switch");
      cap(3'b010, 32'hDEAD_BEEF);
      exp_rsp(3'b010, 32'hDEAD_BEEF, "R6 AP read result from retrieval");
      issue(1'b1, 2'b11, 1'b1, 32'hFFFF_FFFF);

      // next AP access must reload the AP instruction
      exp_ir(4'hB, "R7 AP instruction reloaded");
      exp_dr(2'b11, 1'b0, 32'h1234_5678, "R4 AP write data");
      cap(3'b010, 32'h0);
      exp_rsp(3'b010, 32'h0, "R5 write after reload");
      issue(1'b1, 2'b11, 1'b0, 32'h1234_5678);

      // WAIT twice, then OK
      for (int i = 0; i < 3; i++) exp_dr(2'b11, 1'b0, 32'h0000_A5A5, "R8 identical retry payload");
      cap(3'b001, 32'h0); cap(3'b001, 32'h0); cap(3'b010, 32'h0);
      exp_rsp(3'b010, 32'h0, "R8 recovered after wait");
      issue(1'b1, 2'b11, 1'b0, 32'h0000_A5A5);

      // WAIT on every try: limit reached, no retrieval
      for (int i = 0; i < 5; i++) begin
         exp_dr(2'b11, 1'b1, 32'h0, "R8 retry of read");
         cap(3'b001, 32'h0);
      end
      exp_rsp(3'b001, 32'h0, "R8 wait exhausted");
      issue(1'b1, 2'b11, 1'b1, 32'h0);

      // fault code on a read: ends at once
      exp_dr(2'b00, 1'b1, 32'h0, "R9 read with fault");
      cap(3'b100, 32'hCAFE_0000);
      exp_rsp(3'b100, 32'h0, "R9 fault response");
      issue(1'b1, 2'b00, 1'b1, 32'h0);

      // back to DP after AP: reload, read
      exp_ir(4'hA, "R2 back to DP instruction");
      exp_dr(2'b01, 1'b1, 32'h0, "R4 DP read addr 1");
      cap(3'b010, 32'h0);
      exp_dr(2'b11, 1'b1, 32'h0, "R6 DP retrieval");
      cap(3'b010, 32'h0000_0011);
      exp_rsp(3'b010, 32'h0000_0011, "R6 DP read result");
      issue(1'b0, 2'b01, 1'b1, 32'h0);

      repeat (6) @(negedge clk);
      chk("R3 all expected scans seen", 64'(exp_scan.size()), 64'd0);
      chk("R5 all expected responses seen", 64'(exp_resp.size()), 64'd0);
      summary();
      $finish;
   end
endmodule